// File: doc/BRIEF.md
# Clock-Select Register File with Per-Field Write Enables

This block holds the clock-select words that steer divider ratios and clock-mux choices elsewhere in the chip. Software reaches it over a simple word-addressed register bus. The select word numbered n sits at byte offset 4·(n−1). Inside each word, every field reserves its own most significant bit as an in-band write enable. A write changes a field only if that bit is set in the write data, so several agents can each program their own field in a shared word without a read-modify-write.

Two of the words, the bus-clock divider word and the memory-clock divider word, are held in shadow copies. Writes to them land only in the shadow. The live outputs take the new settings when software writes 1 to the request word. The request bit stays at 1 while the change is in flight and clears itself once the live outputs carry the new values. Software polls the bit until it reads 0. The word at offset 0x00 has no shadow and drives its live output directly.

Top module: `clksel_regfile`

## Requirements
- R1: After a synchronous reset the words read back 0x0000_0019 at 0x00, 0x0033_338F at 0x20 and 0x0000_0099 at 0x24. The request bit at 0x28 (bit 0) reads 0. The live outputs carry these same values.
- R2: A write to an implemented word changes a field only when the field's top bit is 1 in the write data. Fields whose top bit is 0 keep their value. The field ranges are [2:0], [7:3] and [12:8] at 0x00; [6:0], [11:7], [15:12], [19:16] and [23:20] at 0x20; and [2:0], [6:3] and [9:7] at 0x24.
- R3: Write-enable bits, and bits outside every field, always read back as 0.
- R4: The live output of the word at 0x00 (live_sel[31:0]) takes a write at the same clock edge that takes the write.
- R5: Writes to 0x20 and 0x24 leave their live outputs (live_sel[287:256] and live_sel[319:288]) unchanged until a commit completes.
- R6: Reads of 0x20 and 0x24 return the programmed shadow value, not the live value.
- R7: A write of 1 in bit 0 of 0x28 while no commit is pending sets the request bit from the next cycle. At the COMMIT_CYCLES-th edge after the request, both live outputs take the shadow values held just before that edge, and the request bit returns to 0.
- R8: A request written while a commit is pending does not restart or extend it. Writing 0 in bit 0 of 0x28 has no effect.
- R9: Addresses other than 0x00, 0x20, 0x24 and 0x28 read 0, and writes to them change nothing. Byte-address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | 32 | Write data, including the per-field enable bits |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| live_sel | output | 10·32 | Live select words; word k sits in bits [32k+31:32k] |

## Verification
A write is visible in the readback, and for the direct word on its live output, at the first falling edge after the rising edge that takes it. The committed live values and the cleared request bit are due at the falling edge after the COMMIT_CYCLES-th rising edge that follows the request edge. The bench advances a behavioural model on every rising edge from the same inputs the block sees. On every falling edge it compares the whole live vector and the readback for the current address. Directed checks count their falling edges from the write that caused them.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int DATA_W    = 32;
    localparam int CFG_WORDS = 10;
    localparam int REQ_IDX   = 10;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        word_t top;       // enable bit of every field
        word_t used;      // all bits that belong to some field
        word_t rst_val;   // value after reset (enable bits clear)
        logic  shadowed;  // word needs a commit to reach its live output
    } layout_t;

    function automatic layout_t word_layout(int idx);
        layout_t l;
        l = '0;
        case (idx)
            0: begin
                l.top = 32'h0000_1084; l.used = 32'h0000_1FFF;
                l.rst_val = 32'h0000_0019; l.shadowed = 1'b0;
            end
            8: begin
                l.top = 32'h0088_8840; l.used = 32'h00FF_FFFF;
                l.rst_val = 32'h0033_338F; l.shadowed = 1'b1;
            end
            9: begin
                l.top = 32'h0000_0244; l.used = 32'h0000_03FF;
                l.rst_val = 32'h0000_0099; l.shadowed = 1'b1;
            end
            default: l = '0;
        endcase
        return l;
    endfunction

    // Scan from the top down: an enable bit opens a field, and the data bits
    // beneath it follow that enable until the next enable bit is reached.
    function automatic word_t merge_fields(word_t old, word_t wd, word_t top, word_t used);
        word_t res;
        logic  en;
        res = '0;
        en  = 1'b0;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            if (top[b])
                en = wd[b];
            else if (used[b])
                res[b] = en ? wd[b] : old[b];
        end
        return res;
    endfunction

endpackage

// File: rtl/clksel_field_word.sv
module clksel_field_word
    import clksel_pkg::*;
#(
    parameter word_t TOP_MASK  = '0,
    parameter word_t USED_MASK = '0,
    parameter word_t RST_VAL   = '0,
    parameter bit    SHADOWED  = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wdata,
    input  logic  apply,
    output word_t stored,
    output word_t live
);

    localparam word_t RST_CLEAN = RST_VAL & USED_MASK & ~TOP_MASK;

    word_t merged;
    logic  live_load;

    assign merged    = merge_fields(stored, wdata, TOP_MASK, USED_MASK);
    assign live_load = SHADOWED ? apply : wr_en;

    always_ff @(posedge clk) begin
        if (rst)
            stored <= RST_CLEAN;
        else if (wr_en)
            stored <= merged;
    end

    always_ff @(posedge clk) begin
        if (rst)
            live <= RST_CLEAN;
        else if (live_load)
            live <= SHADOWED ? stored : merged;
    end

    // R2: a write with no enable bit set leaves the word alone
    a_r2_no_enable_no_change: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ((wdata & TOP_MASK) == '0)) |=> $stable(stored));

    // R5: a shadowed live word moves only on a commit
    a_r5_shadow_holds: assert property (@(posedge clk) disable iff (rst)
        (SHADOWED && !apply) |=> $stable(live));

    // R4: a direct word's live output tracks its stored value
    a_r4_direct_tracks: assert property (@(posedge clk) disable iff (rst)
        !SHADOWED |-> (live == stored));

endmodule

// File: rtl/clksel_commit_ctrl.sv
module clksel_commit_ctrl #(
    parameter int COMMIT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic req_wr,
    input  logic req_bit,
    output logic busy,
    output logic apply
);

    localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    assign apply = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == '0)
                busy <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end else if (req_wr && req_bit) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(COMMIT_CYCLES - 1);
        end
    end

    // R7: an accepted request raises the pending bit
    a_r7_request_sets: assert property (@(posedge clk) disable iff (rst)
        (req_wr && req_bit && !busy) |=> busy);

    // R7: the pending bit drops right after the settings are applied
    a_r7_clears_after_apply: assert property (@(posedge clk) disable iff (rst)
        apply |=> !busy);

    // R8: a pending commit is never cut short or restarted
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !apply) |=> (busy && (cnt == $past(cnt) - 1'b1)));

endmodule

// File: rtl/clksel_regfile.sv
module clksel_regfile
    import clksel_pkg::*;
#(
    parameter int ADDR_W        = 6,
    parameter int COMMIT_CYCLES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic [CFG_WORDS*DATA_W-1:0] live_sel
);

    logic [ADDR_W-1:0] word_idx;
    word_t             stored_arr [CFG_WORDS];
    logic              commit_busy;
    logic              commit_apply;
    logic              req_wr;

    assign word_idx = bus_addr >> 2;
    assign req_wr   = bus_wr && (word_idx == ADDR_W'(REQ_IDX));

    clksel_commit_ctrl #(
        .COMMIT_CYCLES (COMMIT_CYCLES)
    ) u_commit (
        .clk     (clk),
        .rst     (rst),
        .req_wr  (req_wr),
        .req_bit (bus_wdata[0]),
        .busy    (commit_busy),
        .apply   (commit_apply)
    );

    for (genvar i = 0; i < CFG_WORDS; i++) begin : g_cfg
        localparam layout_t LAY = word_layout(i);
        if (LAY.used != '0) begin : g_word
            logic wr_hit;
            assign wr_hit = bus_wr && (word_idx == ADDR_W'(i));
            clksel_field_word #(
                .TOP_MASK  (LAY.top),
                .USED_MASK (LAY.used),
                .RST_VAL   (LAY.rst_val),
                .SHADOWED  (LAY.shadowed)
            ) u_word (
                .clk    (clk),
                .rst    (rst),
                .wr_en  (wr_hit),
                .wdata  (bus_wdata),
                .apply  (commit_apply),
                .stored (stored_arr[i]),
                .live   (live_sel[i*DATA_W +: DATA_W])
            );
        end else begin : g_empty
            assign stored_arr[i]                = '0;
            assign live_sel[i*DATA_W +: DATA_W] = '0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < CFG_WORDS; i++) begin
            if (word_idx == ADDR_W'(i))
                bus_rdata = stored_arr[i];
        end
        if (word_idx == ADDR_W'(REQ_IDX))
            bus_rdata = {{(DATA_W-1){1'b0}}, commit_busy};
    end

    // R9: addresses beyond the request word read as zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (word_idx > ADDR_W'(REQ_IDX)) |-> (bus_rdata == '0));

endmodule

// File: tb/test_clksel_regfile.sv
module test_clksel_regfile;

    localparam int ADDR_W = 6;
    localparam int N      = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [319:0]      live_sel;

    always #5 clk = ~clk;

    clksel_regfile #(.ADDR_W(ADDR_W), .COMMIT_CYCLES(N)) i_clksel_regfile (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .live_sel(live_sel)
    );

    int   checks = 0;
    int   errors = 0;
    logic done   = 1'b0;

    // behavioural reference state
    logic [31:0] m_w0, m_sh9, m_sh10, m_lv9, m_lv10;
    logic        m_busy;
    int          m_cnt;

    function automatic logic [31:0] model_write(int word, logic [31:0] old, logic [31:0] wd);
        int his[$];
        int los[$];
        case (word)
            0:       begin his = '{2, 7, 12};          los = '{0, 3, 8}; end
            8:       begin his = '{6, 11, 15, 19, 23}; los = '{0, 7, 12, 16, 20}; end
            default: begin his = '{2, 6, 9};           los = '{0, 3, 7}; end
        endcase
        for (int f = 0; f < his.size(); f++)
            if (wd[his[f]])
                for (int b = los[f]; b < his[f]; b++) old[b] = wd[b];
        return old;
    endfunction

    function automatic logic [31:0] model_read(logic [ADDR_W-1:0] a);
        case (a >> 2)
            0:       return m_w0;
            8:       return m_sh9;
            9:       return m_sh10;
            10:      return {31'b0, m_busy};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic was_busy;
        was_busy = m_busy;
        if (rst) begin
            m_w0 = 32'h19; m_sh9 = 32'h0033_338F; m_sh10 = 32'h99;
            m_lv9 = m_sh9; m_lv10 = m_sh10; m_busy = 1'b0; m_cnt = 0;
        end else begin
            if (m_busy) begin
                if (m_cnt == 0) begin
                    m_lv9 = m_sh9; m_lv10 = m_sh10; m_busy = 1'b0;
                end else m_cnt--;
            end
            if (bus_wr) begin
                case (bus_addr >> 2)
                    0:  m_w0   = model_write(0, m_w0, bus_wdata);
                    8:  m_sh9  = model_write(8, m_sh9, bus_wdata);
                    9:  m_sh10 = model_write(9, m_sh10, bus_wdata);
                    10: if (bus_wdata[0] && !was_busy) begin m_busy = 1'b1; m_cnt = N - 1; end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // every falling edge: whole live vector and current readback
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4 live direct word", live_sel[31:0], m_w0);
            check("R5 live word 0x20", live_sel[8*32 +: 32], m_lv9);
            check("R5 live word 0x24", live_sel[9*32 +: 32], m_lv10);
            check("R9 live unused words", {8'h0, live_sel[255:32] == '0 ? 24'h0 : 24'hFFFFFF}, 32'h0);
            check("R6 readback", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        errors++;
        $display("FAIL R7 watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [ADDR_W-1:0] addrs [8];
        addrs = '{6'h00, 6'h20, 6'h24, 6'h28, 6'h28, 6'h14, 6'h3C, 6'h22};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        rd(6'h00, 32'h19, "R1 reset word 0x00");
        rd(6'h20, 32'h0033_338F, "R1 reset word 0x20");
        rd(6'h24, 32'h99, "R1 reset word 0x24");
        rd(6'h28, 32'h0, "R1 reset request bit");
        check("R1 reset live 0x24", live_sel[9*32 +: 32], 32'h99);

        wr(6'h00, 32'h0000_00A8);     // only field [7:3] enabled, value 5
        rd(6'h00, 32'h29, "R2 gated field write");
        check("R4 direct live same edge", live_sel[31:0], 32'h29);

        wr(6'h00, 32'h0000_1FFF);
        rd(6'h00, 32'h0F7B, "R3 enable bits read 0");

        wr(6'h20, 32'h00F0_0000);     // top field enabled, value 7
        rd(6'h20, 32'h0073_338F, "R6 shadow readback");
        check("R5 live held before commit", live_sel[8*32 +: 32], 32'h0033_338F);
        wr(6'h24, 32'h0000_0380);
        rd(6'h24, 32'h199, "R6 shadow readback 0x24");

        wr(6'h28, 32'h1);
        rd(6'h28, 32'h1, "R7 request pending");
        wr(6'h28, 32'h1);             // second request while pending
        repeat (N - 3) @(negedge clk);
        #2;
        rd(6'h28, 32'h1, "R8 still pending, not restarted");
        check("R5 live held during commit", live_sel[8*32 +: 32], 32'h0033_338F);
        @(negedge clk); #2;
        rd(6'h28, 32'h0, "R7 request cleared");
        check("R7 committed 0x20", live_sel[8*32 +: 32], 32'h0073_338F);
        check("R7 committed 0x24", live_sel[9*32 +: 32], 32'h199);
        @(negedge clk); #2;
        rd(6'h28, 32'h0, "R8 no restart after completion");

        wr(6'h28, 32'h0);
        rd(6'h28, 32'h0, "R8 zero write no request");

        wr(6'h30, 32'hFFFF_FFFF);
        rd(6'h30, 32'h0, "R9 unmapped read");
        wr(6'h14, 32'hFFFF_FFFF);
        rd(6'h14, 32'h0, "R9 unused slot read");
        rd(6'h03, 32'h0F7B, "R9 low address bits ignored");
        check("R9 direct word untouched", live_sel[31:0], 32'h0F7B);

        repeat (400) begin
            @(negedge clk); #2;
            bus_wr    = 1'($urandom % 2);
            bus_addr  = addrs[$urandom % 8];
            bus_wdata = $urandom;
        end
        @(negedge clk); #2;
        bus_wr = 1'b0;
        repeat (N + 2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule